// File: doc/BRIEF.md
# Integer Execute ALU with Branch Comparator

This block is the purely combinational datapath of the execute stage of a 32-bit base-integer processor pipeline. It takes two operands, a 4-bit operation code and a 3-bit branch condition code. From these it produces a result word and a flag that says whether a conditional branch is taken. The result and the flag are computed in parallel and do not depend on each other. A pipeline therefore resolves a branch in the same stage in which an arithmetic instruction completes.

The operation set has ten members: add and subtract, the three bitwise operations, three shifts, and two set-less-than forms. Add, subtract and both set-less-than forms share one carry-propagate adder. Two variants are chosen by parameter:
- The shifter is either a staged logarithmic shifter with bit reversal for left shifts, or plain operator shifts.
- The branch comparator either owns a dedicated subtractor or uses magnitude comparators.

The block does not select forwarded operands, generate immediates or add branch targets.

Top module: `exec_alu`

## Requirements
- R1: With operation code 0000 the result is op_a + op_b, and with 1000 it is op_a - op_b, both modulo 2^32 with no overflow indication.
- R2: Operation codes 0111, 0110 and 0100 give the bitwise AND, OR and XOR of the operands.
- R3: Operation code 0001 shifts op_a left, filling with zeros. The shift amount is op_b[4:0] only, and the upper bits of op_b have no effect.
- R4: Operation code 0101 shifts op_a right, filling with zeros. Operation code 1101 shifts op_a right and fills the vacated bits with copies of op_a[31]. Both take the amount from op_b[4:0].
- R5: Operation code 0010 gives 1 when op_a < op_b as two's-complement numbers, and 0011 gives 1 when op_a < op_b as unsigned numbers. Otherwise the result is 0, and in both cases bits 31:1 of the result are zero.
- R6: Every other operation code (1001, 1010, 1011, 1100, 1110, 1111) gives a result of zero.
- R7: Condition code 000 makes the branch flag 1 exactly when the operands are equal, and 001 exactly when they differ.
- R8: Condition code 100 makes the branch flag 1 when op_a < op_b signed, and 101 when op_a >= op_b signed.
- R9: Condition code 110 makes the branch flag 1 when op_a < op_b unsigned, and 111 when op_a >= op_b unsigned.
- R10: Condition codes 010 and 011 always give a branch flag of 0.
- R11: The branch flag depends only on the operands and the condition code, whatever the operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand; bits 4:0 also give the shift amount |
| alu_op_i | input | 4 | Operation code |
| br_cond_i | input | 3 | Branch condition code |
| result_o | output | 32 | Operation result |
| br_taken_o | output | 1 | Branch condition holds |

## Verification
The checks are immediate assertions evaluated whenever the inputs change. They take for granted that all four inputs carry known values and change together, so that no check sees a half-updated set of operands and codes. The stimulus drives every input in one step shortly after a clock edge and only with defined values. The outputs are then compared against the reference model half a period later, once all combinational paths have settled. Invalid operation and condition codes are part of the stimulus on purpose, because the requirements define their outcome.

// File: rtl/exec_alu_pkg.sv
`timescale 1ns/1ps
package exec_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'b0000,
      OP_SLL  = 4'b0001,
      OP_SLT  = 4'b0010,
      OP_SLTU = 4'b0011,
      OP_XOR  = 4'b0100,
      OP_SRL  = 4'b0101,
      OP_OR   = 4'b0110,
      OP_AND  = 4'b0111,
      OP_SUB  = 4'b1000,
      OP_SRA  = 4'b1101
   } alu_op_e;

   typedef enum logic [2:0] {
      BR_EQ  = 3'b000,
      BR_NE  = 3'b001,
      BR_LT  = 3'b100,
      BR_GE  = 3'b101,
      BR_LTU = 3'b110,
      BR_GEU = 3'b111
   } br_cond_e;

   // Variant selectors
   localparam int SHIFT_STAGED   = 0;
   localparam int SHIFT_OPERATOR = 1;
   localparam int CMP_SUBTRACT   = 0;
   localparam int CMP_MAGNITUDE  = 1;

endpackage

// File: rtl/exec_alu_addsub.sv
`timescale 1ns/1ps
// Shared carry-propagate adder: sum or difference plus the
// two less-than flags that a subtraction yields.
module exec_alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         lt_s_o,
   output logic         lt_u_o
);
   localparam int WE = W + 1;

   logic [W-1:0]  b_eff;
   logic [WE-1:0] wide;
   logic          carry;
   logic          ovf;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
   assign sum_o = wide[W-1:0];
   assign carry = wide[W];

   // Two's-complement overflow: like-signed inputs, unlike-signed sum
   assign ovf    = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
   assign lt_s_o = sum_o[W-1] ^ ovf;
   // In a subtraction a borrow (no carry out) means a < b unsigned
   assign lt_u_o = sub_i & ~carry;
endmodule

// File: rtl/exec_alu_shift.sv
`timescale 1ns/1ps
// Shifter with two build variants chosen by IMPL.
module exec_alu_shift
   import exec_alu_pkg::*;
#(
   parameter int W    = 32,
   parameter int IMPL = SHIFT_STAGED,
   localparam int SHW = $clog2(W)
) (
   input  logic [W-1:0]   a_i,
   input  logic [SHW-1:0] shamt_i,
   input  logic           left_i,
   input  logic           arith_i,
   output logic [W-1:0]   y_o
);
   generate
      if (IMPL == SHIFT_STAGED) begin : g_staged
         logic [W-1:0] a_rev;
         logic [W-1:0] out_rev;
         logic [W-1:0] stg [SHW+1];
         logic         fill;

         for (genvar i = 0; i < W; i++) begin : g_rev
            assign a_rev[i] = a_i[W-1-i];
         end

         // Left shifts reuse the right-shift path on reversed data
         assign fill   = arith_i & ~left_i & a_i[W-1];
         assign stg[0] = left_i ? a_rev : a_i;

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stg[s+1] = shamt_i[s]
                              ? {{STEP{fill}}, stg[s][W-1:STEP]}
                              : stg[s];
         end

         for (genvar i = 0; i < W; i++) begin : g_unrev
            assign out_rev[i] = stg[SHW][W-1-i];
         end

         assign y_o = left_i ? out_rev : stg[SHW];
      end else begin : g_operator
         logic signed [W-1:0] a_s;
         assign a_s = a_i;
         always_comb begin
            if (left_i)       y_o = a_i << shamt_i;
            else if (arith_i) y_o = a_s >>> shamt_i;
            else              y_o = a_i >> shamt_i;
         end
      end
   endgenerate
endmodule

// File: rtl/exec_alu_logic.sv
`timescale 1ns/1ps
// Bitwise unit; sel is the low two bits of the operation code.
module exec_alu_logic #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [1:0]   sel_i,
   output logic [W-1:0] y_o
);
   always_comb begin
      case (sel_i)
         2'b00:   y_o = a_i ^ b_i;
         2'b10:   y_o = a_i | b_i;
         2'b11:   y_o = a_i & b_i;
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/exec_br_cmp.sv
`timescale 1ns/1ps
// Six-way branch comparator, independent of the ALU adder.
module exec_br_cmp
   import exec_alu_pkg::*;
#(
   parameter int W    = 32,
   parameter int IMPL = CMP_SUBTRACT
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [2:0]   cond_i,
   output logic         taken_o
);
   logic eq, lt_s, lt_u;

   generate
      if (IMPL == CMP_SUBTRACT) begin : g_sub
         logic [W-1:0] diff;
         exec_alu_addsub #(.W(W)) u_cmp_sub (
            .a_i    (a_i),
            .b_i    (b_i),
            .sub_i  (1'b1),
            .sum_o  (diff),
            .lt_s_o (lt_s),
            .lt_u_o (lt_u)
         );
         assign eq = (diff == '0);
      end else begin : g_mag
         logic signed [W-1:0] a_s, b_s;
         assign a_s  = a_i;
         assign b_s  = b_i;
         assign eq   = (a_i == b_i);
         assign lt_s = (a_s < b_s);
         assign lt_u = (a_i < b_i);
      end
   endgenerate

   always_comb begin
      case (cond_i)
         BR_EQ:   taken_o = eq;
         BR_NE:   taken_o = ~eq;
         BR_LT:   taken_o = lt_s;
         BR_GE:   taken_o = ~lt_s;
         BR_LTU:  taken_o = lt_u;
         BR_GEU:  taken_o = ~lt_u;
         default: taken_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/exec_alu.sv
`timescale 1ns/1ps
module exec_alu
   import exec_alu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int SHIFT_IMPL = SHIFT_STAGED,
   parameter int CMP_IMPL   = CMP_SUBTRACT,
   localparam int SHW       = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] op_a_i,
   input  logic [XLEN-1:0] op_b_i,
   input  logic [3:0]      alu_op_i,
   input  logic [2:0]      br_cond_i,
   output logic [XLEN-1:0] result_o,
   output logic            br_taken_o
);
   // Elaboration-time parameter checks
   generate
      if (XLEN < 8 || (1 << SHW) != XLEN) begin : g_bad_xlen
         $error("exec_alu: XLEN must be a power of two of at least 8");
      end
      if (SHIFT_IMPL != SHIFT_STAGED && SHIFT_IMPL != SHIFT_OPERATOR) begin : g_bad_shift
         $error("exec_alu: unknown SHIFT_IMPL");
      end
      if (CMP_IMPL != CMP_SUBTRACT && CMP_IMPL != CMP_MAGNITUDE) begin : g_bad_cmp
         $error("exec_alu: unknown CMP_IMPL");
      end
   endgenerate

   logic            use_sub;
   logic [XLEN-1:0] sum;
   logic            lt_s, lt_u;
   logic [XLEN-1:0] shift_y;
   logic [XLEN-1:0] logic_y;

   // Subtract for SUB and for both set-less-than forms
   assign use_sub = (alu_op_i == OP_SUB) || (alu_op_i == OP_SLT) ||
                    (alu_op_i == OP_SLTU);

   exec_alu_addsub #(.W(XLEN)) u_addsub (
      .a_i    (op_a_i),
      .b_i    (op_b_i),
      .sub_i  (use_sub),
      .sum_o  (sum),
      .lt_s_o (lt_s),
      .lt_u_o (lt_u)
   );

   exec_alu_shift #(.W(XLEN), .IMPL(SHIFT_IMPL)) u_shift (
      .a_i     (op_a_i),
      .shamt_i (op_b_i[SHW-1:0]),
      .left_i  (alu_op_i == OP_SLL),
      .arith_i (alu_op_i[3]),
      .y_o     (shift_y)
   );

   exec_alu_logic #(.W(XLEN)) u_logic (
      .a_i   (op_a_i),
      .b_i   (op_b_i),
      .sel_i (alu_op_i[1:0]),
      .y_o   (logic_y)
   );

   exec_br_cmp #(.W(XLEN), .IMPL(CMP_IMPL)) u_br (
      .a_i     (op_a_i),
      .b_i     (op_b_i),
      .cond_i  (br_cond_i),
      .taken_o (br_taken_o)
   );

   always_comb begin
      case (alu_op_i)
         OP_ADD, OP_SUB:          result_o = sum;
         OP_SLT:                  result_o = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU:                 result_o = {{(XLEN-1){1'b0}}, lt_u};
         OP_SLL, OP_SRL, OP_SRA:  result_o = shift_y;
         OP_XOR, OP_OR, OP_AND:   result_o = logic_y;
         default:                 result_o = '0;
      endcase
   end
endmodule

// File: rtl/exec_alu_chk.sv
`timescale 1ns/1ps
module exec_alu_chk
   import exec_alu_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int SHW = $clog2(XLEN)
) (
   input logic [XLEN-1:0] op_a_i,
   input logic [XLEN-1:0] op_b_i,
   input logic [3:0]      alu_op_i,
   input logic [2:0]      br_cond_i,
   input logic [XLEN-1:0] result_o,
   input logic            br_taken_o
);
   always_comb begin
      if (alu_op_i == OP_SUB && op_a_i == op_b_i) begin
         // R1
         sub_self_zero_chk: assert (result_o == '0)
            else $error("subtracting equal operands gave nonzero");
      end
      if (alu_op_i == OP_SLL && op_b_i[SHW-1:0] == '0) begin
         // R3
         sll_zero_amt_chk: assert (result_o == op_a_i)
            else $error("left shift by zero altered operand");
      end
      if (alu_op_i == OP_SRA && op_a_i[XLEN-1] && op_b_i[SHW-1:0] != '0) begin
         // R4
         sra_sign_fill_chk: assert (result_o[XLEN-1])
            else $error("arithmetic shift lost sign");
      end
      if (alu_op_i == OP_SRL && op_b_i[SHW-1:0] != '0) begin
         // R4
         srl_zero_fill_chk: assert (!result_o[XLEN-1])
            else $error("logical shift filled with one");
      end
      if (alu_op_i == OP_SLT || alu_op_i == OP_SLTU) begin
         // R5
         slt_narrow_chk: assert (result_o[XLEN-1:1] == '0)
            else $error("set-less-than upper bits nonzero");
      end
      if (alu_op_i[3] && alu_op_i != OP_SUB && alu_op_i != OP_SRA) begin
         // R6
         undef_op_zero_chk: assert (result_o == '0)
            else $error("undefined op gave nonzero result");
      end
      if (br_cond_i == BR_EQ && op_a_i == op_b_i) begin
         // R7
         eq_taken_chk: assert (br_taken_o)
            else $error("equal branch not taken on equal operands");
      end
      if ((br_cond_i == BR_GE || br_cond_i == BR_GEU) && op_a_i == op_b_i) begin
         // R8 R9
         ge_equal_chk: assert (br_taken_o)
            else $error("greater-or-equal not taken on equal operands");
      end
      if (br_cond_i == 3'b010 || br_cond_i == 3'b011) begin
         // R10
         undef_cond_chk: assert (!br_taken_o)
            else $error("undefined condition took branch");
      end
   end
endmodule

bind exec_alu exec_alu_chk #(.XLEN(XLEN)) u_chk (
   .op_a_i     (op_a_i),
   .op_b_i     (op_b_i),
   .alu_op_i   (alu_op_i),
   .br_cond_i  (br_cond_i),
   .result_o   (result_o),
   .br_taken_o (br_taken_o)
);

// File: tb/exec_alu_tb.sv
`timescale 1ns/1ps
module exec_alu_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [3:0]  aop  = '0;
   logic [2:0]  cond = '0;
   logic [31:0] result;
   logic        taken;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   exec_alu u_dut (
      .op_a_i     (op_a),
      .op_b_i     (op_b),
      .alu_op_i   (aop),
      .br_cond_i  (cond),
      .result_o   (result),
      .br_taken_o (taken)
   );

   function automatic logic [31:0] ref_res(logic [3:0] o, logic [31:0] a, logic [31:0] b);
      logic signed [31:0] sa;
      logic signed [31:0] sb;
      int sh;
      sa = a; sb = b; sh = int'(b[4:0]);
      case (o)
         4'b0000: return a + b;
         4'b1000: return a - b;
         4'b0111: return a & b;
         4'b0110: return a | b;
         4'b0100: return a ^ b;
         4'b0001: return a << sh;
         4'b0101: return a >> sh;
         4'b1101: begin sa = sa >>> sh; return sa; end
         4'b0010: return (sa < sb) ? 32'd1 : 32'd0;
         4'b0011: return (a < b) ? 32'd1 : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic ref_br(logic [2:0] c, logic [31:0] a, logic [31:0] b);
      logic signed [31:0] sa;
      logic signed [31:0] sb;
      sa = a; sb = b;
      case (c)
         3'b000: return a == b;
         3'b001: return a != b;
         3'b100: return sa < sb;
         3'b101: return sa >= sb;
         3'b110: return a < b;
         3'b111: return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string op_tag(logic [3:0] o);
      case (o)
         4'b0000, 4'b1000: return "R1";
         4'b0111, 4'b0110, 4'b0100: return "R2";
         4'b0001: return "R3";
         4'b0101, 4'b1101: return "R4";
         4'b0010, 4'b0011: return "R5";
         default: return "R6";
      endcase
   endfunction

   // Drive after a rising edge, compare at the following falling edge
   task automatic vec(string tag, logic [3:0] o, logic [2:0] c,
                      logic [31:0] a, logic [31:0] b);
      logic [31:0] exp_r;
      logic        exp_t;
      @(posedge clk);
      #1;
      aop = o; cond = c; op_a = a; op_b = b;
      exp_r = ref_res(o, a, b);
      exp_t = ref_br(c, a, b);
      @(negedge clk);
      n_cmp++;
      if (result !== exp_r || taken !== exp_t) begin
         n_bad++;
         $display("FAIL %s op=%b cond=%b a=%h b=%h actual res=%h br=%b expected res=%h br=%b",
                  tag, o, c, a, b, result, taken, exp_r, exp_t);
      end
   endtask

   initial begin : watchdog
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Reset-state inputs all zero: result zero, equal branch taken (R7)
      vec("R7", 4'b0000, 3'b000, 32'h0, 32'h0);

      // R1 wrap-around
      vec("R1", 4'b0000, 3'b000, 32'h7fffffff, 32'h1);
      vec("R1", 4'b0000, 3'b000, 32'hffffffff, 32'h1);
      vec("R1", 4'b1000, 3'b000, 32'h0, 32'h1);
      vec("R1", 4'b1000, 3'b000, 32'h80000000, 32'h1);
      vec("R1", 4'b1000, 3'b000, 32'h12345678, 32'h12345678);
      // R2 bitwise
      vec("R2", 4'b0111, 3'b000, 32'hf0f0a5a5, 32'hff00_5a5a);
      vec("R2", 4'b0110, 3'b000, 32'hf0f0a5a5, 32'hff00_5a5a);
      vec("R2", 4'b0100, 3'b000, 32'hf0f0a5a5, 32'hff00_5a5a);
      // R3 left shift, upper amount bits ignored
      vec("R3", 4'b0001, 3'b000, 32'h8000_0001, 32'h0);
      vec("R3", 4'b0001, 3'b000, 32'h0000_0003, 32'd31);
      vec("R3", 4'b0001, 3'b000, 32'hdeadbeef, 32'h20);
      vec("R3", 4'b0001, 3'b000, 32'hdeadbeef, 32'hffffffe1);
      // R4 right shifts
      vec("R4", 4'b0101, 3'b000, 32'h80000000, 32'd31);
      vec("R4", 4'b1101, 3'b000, 32'h80000000, 32'd31);
      vec("R4", 4'b1101, 3'b000, 32'h80000000, 32'd0);
      vec("R4", 4'b1101, 3'b000, 32'h7fff0000, 32'd4);
      vec("R4", 4'b0101, 3'b000, 32'hf0000000, 32'hffffff04);
      // R5 set-less-than
      vec("R5", 4'b0010, 3'b000, 32'hffffffff, 32'h1);
      vec("R5", 4'b0011, 3'b000, 32'hffffffff, 32'h1);
      vec("R5", 4'b0010, 3'b000, 32'h80000000, 32'h7fffffff);
      vec("R5", 4'b0011, 3'b000, 32'h80000000, 32'h7fffffff);
      vec("R5", 4'b0010, 3'b000, 32'h5, 32'h5);
      // R6 undefined op codes
      for (int k = 0; k < 16; k++) begin
         if (ref_res(4'(k), 32'hffffffff, 32'hffffffff) == 32'h0 &&
             k[3] && k != 8 && k != 13)
            vec("R6", 4'(k), 3'b000, 32'hffffffff, 32'h0000000f);
      end
      // R7 equal / not equal
      vec("R7", 4'b0000, 3'b000, 32'hffffffff, 32'hfffffffe);
      vec("R7", 4'b0000, 3'b001, 32'hffffffff, 32'hfffffffe);
      vec("R7", 4'b0000, 3'b001, 32'h1234, 32'h1234);
      // R8 signed boundaries
      vec("R8", 4'b0000, 3'b100, 32'h80000000, 32'h7fffffff);
      vec("R8", 4'b0000, 3'b101, 32'h80000000, 32'h7fffffff);
      vec("R8", 4'b0000, 3'b101, 32'h80000000, 32'h80000000);
      vec("R8", 4'b0000, 3'b100, 32'hffffffff, 32'h0);
      // R9 unsigned boundaries
      vec("R9", 4'b0000, 3'b110, 32'h80000000, 32'h7fffffff);
      vec("R9", 4'b0000, 3'b111, 32'h7fffffff, 32'h80000000);
      vec("R9", 4'b0000, 3'b111, 32'h0, 32'h0);
      vec("R9", 4'b0000, 3'b110, 32'h0, 32'hffffffff);
      // R10 unused condition codes
      vec("R10", 4'b0000, 3'b010, 32'h5, 32'h5);
      vec("R10", 4'b0000, 3'b011, 32'h1, 32'h2);
      vec("R10", 4'b0000, 3'b010, 32'hffffffff, 32'h0);
      // R11 branch flag the same under every op code
      for (int k = 0; k < 16; k++)
         vec("R11", 4'(k), 3'b100, 32'hfffffff0, 32'h00000010);

      // Random vectors across all codes
      for (int n = 0; n < 600; n++) begin
         logic [3:0] o;
         o = 4'($urandom_range(0, 15));
         vec(op_tag(o), o, 3'($urandom_range(0, 7)), $urandom, $urandom);
      end
      // Random equal operands so equality paths are exercised
      for (int n = 0; n < 40; n++) begin
         logic [31:0] v;
         v = $urandom;
         vec("R7", 4'($urandom_range(0, 15)), 3'($urandom_range(0, 7)), v, v);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule